// File: doc/BRIEF.md
# CAN Error Status and Interrupt Flag Unit

This block keeps the error-reporting state of a CAN controller. The protocol engine gives it a 2-bit fault-confinement state and six single-cycle error-event pulses. The block latches each event into a sticky error bit. It keeps a summary error flag that is set while any error bit is set. It also keeps a bus-off flag that is set when the controller moves into bus-off. Each flag class has its own mask bit, and each class drives its own registered interrupt request line.

Software reaches the block through a one-word write port with byte enables. A select input chooses between two targets. The first is the status word, where every flag and error bit is write-1-to-clear. The second is the mask word, which is written directly. A single read-only status word shows all the flags, the error bits, the masks and the live confinement state. Every pin is plain control or status and has no handshake. A write takes effect at the clock edge where `wr_en` is high, so the port never back-pressures.

Top module: `can_err_status_irq`

## Requirements
- R1: After reset the flags, the six error bits, both mask bits and both interrupt outputs are 0.
- R2: The confinement state codes are 00 = error active, 01 = error passive, and 1X = bus off. When the state high bit goes from 0 to 1, the bus-off flag (status bit 2) reads 1 on the next cycle.
- R3: Staying in bus-off (high bit 1 on consecutive cycles, including 10 to 11) never sets the bus-off flag again after it has been cleared.
- R4: A write with select 0, byte enable 0 set and data bit 2 at 1 clears the bus-off flag. Data bit 2 at 0, or byte enable 0 low, leaves it unchanged.
- R5: Error event pulse i sets error bit i, which sits at status bit 16+i. The error bits are sticky.
- R6: A write with select 0 and byte enable 2 set clears each error bit whose data bit (16+i) is 1. Other error bits, and all error bits when byte enable 2 is low, are unchanged.
- R7: The summary error flag (status bit 1) is set on the cycle after any error bit reads 1.
- R8: A write with select 0, byte enable 0 set and data bit 1 at 1 clears the summary flag. Writing 0 leaves it unchanged.
- R9: When a set condition and a write-1 clear reach the same flag or error bit in the same cycle, the set wins and the bit reads 1.
- R10: A write with select 1 and byte enable 0 set loads the error mask from data bit 0 and the bus-off mask from data bit 1. They read back at status bits 24 and 25. Without byte enable 0 the masks are unchanged.
- R11: Each interrupt output equals the AND of its flag and its mask as they stood one cycle earlier.
- R12: Status bits 5:4 show the present confinement state input. All unlisted status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conf_state | input | 2 | Fault-confinement state from the protocol engine |
| err_evt | input | 6 | Error-event pulses, one per error kind |
| wr_en | input | 1 | Register write strobe |
| wr_sel_mask | input | 1 | 0 = status word (write-1-to-clear), 1 = mask word |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for wr_data |
| status_word | output | 32 | Flags, error bits, masks and confinement state |
| boff_irq | output | 1 | Bus-off interrupt request |
| err_irq | output | 1 | Summary error interrupt request |

## Verification
The bench builds the block with its default parameters: six error bits at bit 16, a 32-bit write word and two interrupt classes. This makes every error bit, both byte lanes that carry flags, and both interrupt gates reachable from the ports. With these values the bench can drive a bus-off entry in the same cycle as a clear, an error event in the same cycle as its clear, and a 10 to 11 move inside bus-off. It also covers writes whose byte enables miss the lane that holds the target bit. A behavioural model predicts the status word and both interrupt lines on every cycle.

// File: rtl/can_esi_pkg.sv
package can_esi_pkg;
  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int N_ERR     = 6;
  localparam int ERR_LSB   = 16;
  localparam int ERRF_BIT  = 1;
  localparam int BOFF_BIT  = 2;
  localparam int STATE_LSB = 4;
  localparam int MASK_LSB  = 24;
  localparam int N_CLS     = 2;
  localparam int CLS_ERR   = 0;
  localparam int CLS_BOFF  = 1;

  typedef logic [1:0] conf_t;

  function automatic logic in_bus_off(input conf_t s);
    return s[1];
  endfunction
endpackage

// File: rtl/cesi_boff_track.sv
module cesi_boff_track
  import can_esi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  conf_t conf_state,
  input  logic  clr,
  output logic  flag
);
  logic was_boff;
  logic entry;

  assign entry = in_bus_off(conf_state) && !was_boff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_boff <= 1'b0;
      flag     <= 1'b0;
    end else begin
      was_boff <= in_bus_off(conf_state);
      if (entry)    flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  AST_BOFF_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!was_boff && conf_state[1]) |=> flag); // R2
  AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (was_boff && conf_state[1] && clr) |=> !flag); // R3
  AST_BOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R4
endmodule

// File: rtl/cesi_err_bank.sv
module cesi_err_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] bit_clr,
  input  logic         sum_clr,
  output logic [N-1:0] bits,
  output logic         sum_flag
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bits[i] <= 1'b0;
      else if (evt[i])     bits[i] <= 1'b1;
      else if (bit_clr[i]) bits[i] <= 1'b0;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (bits[i] && !bit_clr[i]) |=> bits[i]); // R5
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> bits[i]); // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sum_flag <= 1'b0;
    else if (|bits)   sum_flag <= 1'b1;
    else if (sum_clr) sum_flag <= 1'b0;
  end

  AST_SUM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|bits) |=> sum_flag); // R7
  AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_flag && !sum_clr) |=> sum_flag); // R8
endmodule

// File: rtl/cesi_irq_gate.sv
module cesi_irq_gate #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] masks,
  output logic [N-1:0] irq
);
  for (genvar c = 0; c < N; c++) begin : g_cls
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq[c] <= 1'b0;
      else        irq[c] <= flags[c] & masks[c];
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !masks[c] |=> !irq[c]); // R11
    AST_NO_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !flags[c] |=> !irq[c]); // R11
  end
endmodule

// File: rtl/can_err_status_irq.sv
module can_err_status_irq
  import can_esi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        conf_state,
  input  logic [N_ERR-1:0]  err_evt,
  input  logic              wr_en,
  input  logic              wr_sel_mask,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  output logic [DATA_W-1:0] status_word,
  output logic              boff_irq,
  output logic              err_irq
);
  localparam int ERR_BYTE  = ERR_LSB / 8;
  localparam int FLAG_BYTE = 0;

  logic [DATA_W-1:0] w1c;
  logic              mask_we;
  logic [N_CLS-1:0]  mask_q;
  logic [N_CLS-1:0]  flags;
  logic [N_CLS-1:0]  irq_vec;
  logic [N_ERR-1:0]  err_bits;
  logic              sum_flag;
  logic              boff_flag;

  // Byte-lane qualified write-1-to-clear vector for the status target.
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign w1c[b*8 +: 8] = (wr_en && !wr_sel_mask && wr_be[b]) ? wr_data[b*8 +: 8] : 8'h00;
  end

  assign mask_we = wr_en && wr_sel_mask && wr_be[FLAG_BYTE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wr_data[N_CLS-1:0];
  end

  cesi_boff_track u_boff (
    .clk        (clk),
    .rst_n      (rst_n),
    .conf_state (conf_state),
    .clr        (w1c[BOFF_BIT]),
    .flag       (boff_flag)
  );

  cesi_err_bank #(.N(N_ERR)) u_errs (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (err_evt),
    .bit_clr  (w1c[ERR_LSB +: N_ERR]),
    .sum_clr  (w1c[ERRF_BIT]),
    .bits     (err_bits),
    .sum_flag (sum_flag)
  );

  assign flags[CLS_ERR]  = sum_flag;
  assign flags[CLS_BOFF] = boff_flag;

  cesi_irq_gate #(.N(N_CLS)) u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (flags),
    .masks (mask_q),
    .irq   (irq_vec)
  );

  assign err_irq  = irq_vec[CLS_ERR];
  assign boff_irq = irq_vec[CLS_BOFF];

  always_comb begin
    status_word                         = '0;
    status_word[ERRF_BIT]               = sum_flag;
    status_word[BOFF_BIT]               = boff_flag;
    status_word[STATE_LSB +: 2]         = conf_state;
    status_word[ERR_LSB +: N_ERR]       = err_bits;
    status_word[MASK_LSB +: N_CLS]      = mask_q;
  end

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q)); // R10
  AST_ERR_BYTE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_be[ERR_BYTE] && err_bits[0]) |=> err_bits[0]); // R6
endmodule

// File: tb/can_err_status_irq_test.sv
`timescale 1ns/1ps
module can_err_status_irq_test;
  localparam time HALF = 10ns; // 50 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  conf_state = 2'b00;
  logic [5:0]  err_evt = '0;
  logic        wr_en = 1'b0;
  logic        wr_sel_mask = 1'b0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] status_word;
  logic        boff_irq, err_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  string phase = "R1";

  always #HALF clk = ~clk;

  can_err_status_irq uut (
    .clk(clk), .rst_n(rst_n), .conf_state(conf_state), .err_evt(err_evt),
    .wr_en(wr_en), .wr_sel_mask(wr_sel_mask), .wr_data(wr_data), .wr_be(wr_be),
    .status_word(status_word), .boff_irq(boff_irq), .err_irq(err_irq)
  );

  // Behavioural reference model
  bit       m_boff, m_sum, m_prev_hi, m_ib, m_ie;
  bit [5:0] m_bits;
  bit [1:0] m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_boff = 0; m_sum = 0; m_prev_hi = 0; m_ib = 0; m_ie = 0;
      m_bits = 0; m_mask = 0;
    end else begin
      bit [7:0] c0, c2;
      bit       nb, ns;
      bit [5:0] nbits;
      c0 = (wr_en && !wr_sel_mask && wr_be[0]) ? wr_data[7:0]   : 8'h0;
      c2 = (wr_en && !wr_sel_mask && wr_be[2]) ? wr_data[23:16] : 8'h0;
      m_ie = m_sum & m_mask[0];
      m_ib = m_boff & m_mask[1];
      if (!m_prev_hi && conf_state[1]) nb = 1;
      else if (c0[2]) nb = 0;
      else nb = m_boff;
      if (m_bits != 0) ns = 1;
      else if (c0[1]) ns = 0;
      else ns = m_sum;
      nbits = (m_bits & ~c2[5:0]) | err_evt;
      if (wr_en && wr_sel_mask && wr_be[0]) m_mask = wr_data[1:0];
      m_prev_hi = conf_state[1];
      m_boff = nb; m_sum = ns; m_bits = nbits;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge, before the bench drives new inputs.
  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] exp;
      exp = '0;
      exp[1] = m_sum; exp[2] = m_boff; exp[5:4] = conf_state;
      exp[21:16] = m_bits; exp[25:24] = m_mask;
      chk("status_word", status_word, exp);
      chk("boff_irq", {31'b0, boff_irq}, {31'b0, m_ib});
      chk("err_irq",  {31'b0, err_irq},  {31'b0, m_ie});
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #(HALF + 1ns);
    err_evt = '0; wr_en = 0; wr_be = '0; wr_data = '0; wr_sel_mask = 0;
  endtask

  task automatic wr(bit sel, logic [3:0] be, logic [31:0] d);
    wr_en = 1; wr_sel_mask = sel; wr_be = be; wr_data = d;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    phase = "R1";
    repeat (3) @(posedge clk);
    #(HALF + 1ns);
    rst_n = 1;
    cyc(3);
    // R12 state visibility, R2 entry from 01
    phase = "R12"; conf_state = 2'b01; cyc(2);
    phase = "R2";  conf_state = 2'b10; cyc(3);
    // R3: clear while staying in bus-off; 10 -> 11 must not re-set
    phase = "R3";  wr(0, 4'h1, 32'h4); cyc(1);
    conf_state = 2'b11; cyc(3);
    conf_state = 2'b10; cyc(2);
    phase = "R2";  conf_state = 2'b00; cyc(2);
    conf_state = 2'b11; cyc(2);
    // R4: write 0, wrong lane, then real clear
    phase = "R4";  wr(0, 4'h1, 32'h0); cyc(2);
    wr(0, 4'hE, 32'hFFFF_FFFF); cyc(2);
    wr(0, 4'h1, 32'h4); cyc(2);
    // R9: entry and clear in the same cycle
    phase = "R9";  conf_state = 2'b00; cyc(1);
    conf_state = 2'b01; cyc(1);
    conf_state = 2'b10; wr(0, 4'h1, 32'h4); cyc(2);
    // R10/R11 masks and interrupt gating
    phase = "R10"; wr(1, 4'h1, 32'h2); cyc(2);
    wr(1, 4'hE, 32'h0); cyc(2);
    phase = "R11"; wr(0, 4'h1, 32'h4); cyc(3);
    conf_state = 2'b00; cyc(1);
    conf_state = 2'b10; cyc(3);
    // R5 sticky error bits, R7 summary
    phase = "R5";  err_evt = 6'b000001; cyc(1);
    err_evt = 6'b100000; cyc(1);
    err_evt = 6'b010100; cyc(3);
    phase = "R7";  wr(1, 4'h1, 32'h3); cyc(3);
    // R8: clearing summary while bits set -> stays
    phase = "R8";  wr(0, 4'h1, 32'h2); cyc(2);
    // R6: wrong lane, partial clear, then full
    phase = "R6";  wr(0, 4'hB, 32'h003F_0000); cyc(2);
    wr(0, 4'h4, 32'h0001_0000); cyc(2);
    // R9: event and clear of the same bit in one cycle
    phase = "R9";  err_evt = 6'b000010; wr(0, 4'h4, 32'h0002_0000); cyc(2);
    phase = "R6";  wr(0, 4'h4, 32'h003F_0000); cyc(3);
    phase = "R8";  wr(0, 4'h1, 32'h0); cyc(2);
    wr(0, 4'h1, 32'h2); cyc(3);
    // R11: unmask error, remask
    phase = "R11"; err_evt = 6'b001000; cyc(4);
    wr(1, 4'h1, 32'h2); cyc(3);
    wr(0, 4'h5, 32'h0008_0006); cyc(4);
    phase = "R1";  rst_n = 0; cyc(2);
    rst_n = 1; cyc(3);
    finish_run();
  end
endmodule